// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block turns one burst request into the column address of each beat of an SDRAM read or write burst. A one-cycle `start` pulse presents a starting column, a burst length code and an ordering selector. Beat 0 appears on the clock after the pulse, and one further beat follows on each clock until the burst is complete. Every beat is marked by `beat_vld`. The final beat of a fixed-length burst also carries `beat_last`.

Fixed bursts of 2, 4 or 8 beats stay inside an aligned block of that size. The column bits above the block never change during the burst. The low bits either count upward and wrap inside the block (linear order) or take the start offset XOR the beat number (interleaved order). A whole-row burst counts upward through all 256 columns, wraps back to the start column, and runs until `stop` is raised. A request the block cannot serve raises `req_err` for one cycle and produces no beats.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `beat_vld`, `beat_last` and `req_err` are all low.
- R2: A legal request sampled with `start` high yields beat 0 on the next cycle, with `beat_col` equal to `start_col`. Each following beat appears on the next consecutive cycle, and `beat_vld` is high for exactly one cycle per beat.
- R3: `len_sel` encodes the burst length as 0 = 1 beat, 1 = 2 beats, 2 = 4 beats, 3 = 8 beats and 7 = whole row. A fixed burst of N beats asserts `beat_last` only on beat N, and `beat_vld` is low on the cycle after that beat.
- R4: With `ilv_sel` = 0 (linear order) and a length of 2, 4 or 8, beat k has the column bits above the block equal to those of `start_col`. Its low bits are (start low bits + k) modulo the block size. For example, length 8 from offset 5 gives 5-6-7-0-1-2-3-4.
- R5: With `ilv_sel` = 1 (interleaved order) and a length of 2, 4 or 8, beat k has the upper bits of `start_col` and low bits equal to (start low bits XOR k). For example, length 8 from offset 5 gives 5-4-7-6-1-0-3-2, and length 4 from offset 2 gives 2-3-0-1.
- R6: With length 1, the burst is a single beat at `start_col` that carries `beat_last`, and `ilv_sel` has no effect.
- R7: A whole-row linear burst steps the column by +1 modulo 256 on each beat. It returns to `start_col` on beat 256 and never asserts `beat_last`.
- R8: When `stop` is high in a cycle that shows a beat, that beat is the final one, and `beat_vld` is low on the next cycle. This applies to any burst length.
- R9: A request with `len_sel` of 4, 5 or 6, or with `len_sel` = 7 and `ilv_sel` = 1, raises `req_err` for exactly one cycle, on the cycle after `start`. It produces no beat and ends any burst in progress.
- R10: A `start` pulse during an active burst abandons that burst. The new burst's beat 0 follows on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse; loads the burst parameters |
| start_col | input | 8 | Starting column |
| len_sel | input | 3 | Burst length code |
| ilv_sel | input | 1 | 0 = linear order, 1 = interleaved order |
| stop | input | 1 | Ends the burst after the beat currently shown |
| beat_col | output | 8 | Column address of the current beat |
| beat_vld | output | 1 | High for one cycle per beat |
| beat_last | output | 1 | Final beat of a fixed-length burst |
| req_err | output | 1 | One-cycle pulse for an unsupported request |

## Verification
The bench aims at wrap points inside the block. It uses starts at the top offset of a block and upper column bits that are not zero. A design that carried into the upper bits would leave the block instead of wrapping to offset 0. One that mixed up addition and XOR would produce the wrong order on interleaved starts at offsets 3 and 5. The whole-row run goes past 255 and 256 beats. A sequencer that stopped early, raised `beat_last`, or failed to return to the start column is caught there. Aborts by a new request, by an illegal request and by `stop` are each placed in the middle of a burst, which exposes a design that finishes the old burst or emits a beat for an error.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
   typedef enum logic {
      ORD_LINEAR = 1'b0,
      ORD_XOR    = 1'b1
   } beat_order_e;
endpackage

// File: rtl/bcs_len_decode.sv
module bcs_len_decode
   import bcs_pkg::*;
#(
   parameter int COL_W       = 8,
   parameter int LEN_W       = 3,
   parameter int MAX_LOG_LEN = 3
) (
   input  logic [LEN_W-1:0] len_sel,
   input  logic             ilv_sel,
   output logic [COL_W-1:0] blk_mask,
   output logic             row_mode,
   output logic             bad_req,
   output beat_order_e      order
);
   localparam logic [LEN_W-1:0] ROW_CODE = {LEN_W{1'b1}};
   localparam logic [LEN_W-1:0] MAX_CODE = LEN_W'(MAX_LOG_LEN);

   logic fixed_len;

   always_comb begin
      fixed_len = (len_sel <= MAX_CODE);
      row_mode  = (len_sel == ROW_CODE);
      if (row_mode)
         blk_mask = {COL_W{1'b1}};
      else if (fixed_len)
         blk_mask = (COL_W'(1) << len_sel) - COL_W'(1);
      else
         blk_mask = '0;
      bad_req = !(fixed_len || row_mode) || (row_mode && ilv_sel);
      order   = (ilv_sel && fixed_len) ? ORD_XOR : ORD_LINEAR;
   end
endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen
   import bcs_pkg::*;
#(
   parameter int COL_W = 8
) (
   input  logic [COL_W-1:0] base_col,
   input  logic [COL_W-1:0] blk_mask,
   input  logic [COL_W-1:0] beat_idx,
   input  beat_order_e      order,
   output logic [COL_W-1:0] col
);
   logic [COL_W-1:0] lin_sum;

   assign lin_sum = (base_col & blk_mask) + beat_idx;

   for (genvar b = 0; b < COL_W; b++) begin : g_bit
      logic in_blk_bit;
      assign in_blk_bit = (order == ORD_XOR) ? (base_col[b] ^ beat_idx[b]) : lin_sum[b];
      assign col[b]     = blk_mask[b] ? in_blk_bit : base_col[b];
   end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
   import bcs_pkg::*;
#(
   parameter int COL_W       = 8,
   parameter int LEN_W       = 3,
   parameter int MAX_LOG_LEN = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [COL_W-1:0] start_col,
   input  logic [LEN_W-1:0] len_sel,
   input  logic             ilv_sel,
   input  logic             stop,
   output logic [COL_W-1:0] beat_col,
   output logic             beat_vld,
   output logic             beat_last,
   output logic             req_err
);
   if (MAX_LOG_LEN >= COL_W) begin : g_bad_len
      $error("MAX_LOG_LEN must be below COL_W");
   end
   if (MAX_LOG_LEN >= (2**LEN_W) - 1) begin : g_bad_code
      $error("LEN_W too narrow for fixed lengths plus the row code");
   end

   logic [COL_W-1:0] dec_mask;
   logic             dec_row;
   logic             dec_bad;
   beat_order_e      dec_ord;

   logic [COL_W-1:0] base_q, mask_q, idx_q, nxt_col;
   logic             row_q;
   beat_order_e      ord_q;

   bcs_len_decode #(.COL_W(COL_W), .LEN_W(LEN_W), .MAX_LOG_LEN(MAX_LOG_LEN)) u_dec (
      .len_sel  (len_sel),
      .ilv_sel  (ilv_sel),
      .blk_mask (dec_mask),
      .row_mode (dec_row),
      .bad_req  (dec_bad),
      .order    (dec_ord)
   );

   bcs_addr_gen #(.COL_W(COL_W)) u_gen (
      .base_col (base_q),
      .blk_mask (mask_q),
      .beat_idx (idx_q),
      .order    (ord_q),
      .col      (nxt_col)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q    <= '0;
         mask_q    <= '0;
         idx_q     <= '0;
         row_q     <= 1'b0;
         ord_q     <= ORD_LINEAR;
         beat_col  <= '0;
         beat_vld  <= 1'b0;
         beat_last <= 1'b0;
         req_err   <= 1'b0;
      end else begin
         req_err <= 1'b0;
         if (start) begin
            if (dec_bad) begin
               beat_vld  <= 1'b0;
               beat_last <= 1'b0;
               req_err   <= 1'b1;
            end else begin
               beat_vld  <= 1'b1;
               beat_col  <= start_col;
               base_q    <= start_col;
               mask_q    <= dec_mask;
               row_q     <= dec_row;
               ord_q     <= dec_ord;
               idx_q     <= COL_W'(1);
               beat_last <= !dec_row && (dec_mask == '0);
            end
         end else if (beat_vld) begin
            if (stop || beat_last) begin
               beat_vld  <= 1'b0;
               beat_last <= 1'b0;
            end else begin
               beat_col  <= nxt_col;
               idx_q     <= idx_q + COL_W'(1);
               beat_last <= !row_q && (idx_q == mask_q);
            end
         end
      end
   end
endmodule

// File: rtl/bcs_chk.sv
module bcs_chk #(
   parameter int COL_W       = 8,
   parameter int LEN_W       = 3,
   parameter int MAX_LOG_LEN = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [COL_W-1:0] start_col,
   input logic [LEN_W-1:0] len_sel,
   input logic             ilv_sel,
   input logic             stop,
   input logic [COL_W-1:0] beat_col,
   input logic             beat_vld,
   input logic             beat_last,
   input logic             req_err
);
   localparam logic [LEN_W-1:0] ROW_CODE = {LEN_W{1'b1}};

   logic legal;
   logic row_m;

   assign legal = (len_sel <= LEN_W'(MAX_LOG_LEN)) || (len_sel == ROW_CODE && !ilv_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) row_m <= 1'b0;
      else if (start) row_m <= (len_sel == ROW_CODE);
   end

   // R9
   err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(req_err && beat_vld));
   // R3
   last_has_vld_chk: assert property (@(posedge clk) disable iff (!rst_n) beat_last |-> beat_vld);
   // R2
   first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && legal) |=> (beat_vld && beat_col == $past(start_col)));
   // R9
   bad_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !legal) |=> (req_err && !beat_vld));
   // R3
   end_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_vld && beat_last && !start) |=> !beat_vld);
   // R8
   stop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_vld && stop && !start) |=> !beat_vld);
   // R7
   row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_vld && row_m && !stop && !start) |=> (beat_vld && beat_col == $past(beat_col) + COL_W'(1)));
   // R7
   row_no_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_vld && row_m) |-> !beat_last);
endmodule

bind burst_col_seq bcs_chk #(.COL_W(COL_W), .LEN_W(LEN_W), .MAX_LOG_LEN(MAX_LOG_LEN)) u_chk (.*);

// File: tb/burst_col_seq_tb.sv
`timescale 1ns/1ps
module burst_col_seq_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [7:0] start_col = '0;
   logic [2:0] len_sel = '0;
   logic       ilv_sel = 1'b0;
   logic       stop = 1'b0;
   logic [7:0] beat_col;
   logic       beat_vld, beat_last, req_err;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   burst_col_seq u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
      .len_sel(len_sel), .ilv_sel(ilv_sel), .stop(stop),
      .beat_col(beat_col), .beat_vld(beat_vld), .beat_last(beat_last), .req_err(req_err)
   );

   // {start_col, len_sel, ilv_sel, beats, expected columns beat0 in top byte}
   localparam int NV = 11;
   localparam logic [79:0] VEC [NV] = '{
      {8'h2D, 3'd3, 1'b0, 4'd8, 64'h2D2E2F28292A2B2C},  // R4
      {8'h2D, 3'd3, 1'b1, 4'd8, 64'h2D2C2F2E29282B2A},  // R5
      {8'h92, 3'd2, 1'b1, 4'd4, 64'h9293909100000000},  // R5
      {8'h93, 3'd2, 1'b0, 4'd4, 64'h9390919200000000},  // R4
      {8'h93, 3'd2, 1'b1, 4'd4, 64'h9392919000000000},  // R5
      {8'h41, 3'd1, 1'b0, 4'd2, 64'h4140000000000000},  // R4
      {8'h41, 3'd1, 1'b1, 4'd2, 64'h4140000000000000},  // R5
      {8'hF7, 3'd0, 1'b1, 4'd1, 64'hF700000000000000},  // R6
      {8'h00, 3'd0, 1'b0, 4'd1, 64'h0000000000000000},  // R6
      {8'hF8, 3'd3, 1'b0, 4'd8, 64'hF8F9FAFBFCFDFEFF},  // R4
      {8'h07, 3'd3, 1'b1, 4'd8, 64'h0706050403020100}   // R5
   };

   task automatic check(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic issue(logic [7:0] c, logic [2:0] l, logic i);
      @(negedge clk);
      start = 1'b1; start_col = c; len_sel = l; ilv_sel = i;
      @(negedge clk);
      start = 1'b0;
   endtask

   initial begin
      #(4 * 20000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #5;
      // R1
      check("R1 vld", int'(beat_vld), 0);
      check("R1 last", int'(beat_last), 0);
      check("R1 err", int'(req_err), 0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      check("R1 vld idle", int'(beat_vld), 0);

      // R2 R3 R4 R5 R6: vector table
      for (int v = 0; v < NV; v++) begin
         logic [79:0] e;
         int nb;
         e  = VEC[v];
         nb = int'(e[67:64]);
         issue(e[79:72], e[71:69], e[68]);
         for (int k = 0; k < nb; k++) begin
            if (k > 0) @(negedge clk);
            check("R2 vld", int'(beat_vld), 1);
            check("R4/R5 col", int'(beat_col), int'(e[63-8*k -: 8]));
            check("R3 last", int'(beat_last), (k == nb - 1) ? 1 : 0);
         end
         @(negedge clk);
         check("R3 end", int'(beat_vld), 0);
      end

      // R7 whole row from FE, past wrap and return
      issue(8'hFE, 3'd7, 1'b0);
      for (int k = 0; k < 258; k++) begin
         if (k > 0) @(negedge clk);
         check("R7 vld", int'(beat_vld), 1);
         check("R7 col", int'(beat_col), (254 + k) % 256);
         check("R7 last", int'(beat_last), 0);
      end
      // R8 stop on whole row
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      check("R8 row stop", int'(beat_vld), 0);
      @(negedge clk);
      check("R8 stays idle", int'(beat_vld), 0);

      // R8 stop on fixed burst after beat 1
      issue(8'h30, 3'd3, 1'b0);
      @(negedge clk);
      check("R8 beat1", int'(beat_col), 8'h31);
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      check("R8 fixed stop", int'(beat_vld), 0);

      // R9 row + interleave
      issue(8'h12, 3'd7, 1'b1);
      check("R9 err", int'(req_err), 1);
      check("R9 no beat", int'(beat_vld), 0);
      @(negedge clk);
      check("R9 err pulse", int'(req_err), 0);
      check("R9 no beat later", int'(beat_vld), 0);
      // R9 reserved codes 4..6
      for (int c = 4; c < 7; c++) begin
         issue(8'h12, 3'(c), 1'b0);
         check("R9 code err", int'(req_err), 1);
         check("R9 code no beat", int'(beat_vld), 0);
      end
      // R9 illegal request aborts running burst
      issue(8'h50, 3'd3, 1'b0);
      @(negedge clk);
      issue(8'h00, 3'd5, 1'b0);
      check("R9 abort err", int'(req_err), 1);
      check("R9 abort vld", int'(beat_vld), 0);
      @(negedge clk);
      check("R9 abort stays", int'(beat_vld), 0);

      // R10 restart mid-burst
      issue(8'h10, 3'd3, 1'b0);
      @(negedge clk);
      check("R10 old beat1", int'(beat_col), 8'h11);
      issue(8'h41, 3'd1, 1'b0);
      check("R10 new beat0", int'(beat_col), 8'h41);
      check("R10 new vld", int'(beat_vld), 1);
      check("R10 new last0", int'(beat_last), 0);
      @(negedge clk);
      check("R10 new beat1", int'(beat_col), 8'h40);
      check("R10 new last1", int'(beat_last), 1);
      @(negedge clk);
      check("R10 end", int'(beat_vld), 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule